// File: doc/BRIEF.md
# Test Packet Response Checker

This block sits on the core side of a destination node in a mesh on-chip network, where it takes in one interconnect test packet. A start pulse arms it and names the expected source node. The block then rebuilds the whole expected flit stream locally and compares each received flit against it, one flit at a time.

The expected stream has four parts. It opens with a header in its post-routing form. Zero padding follows, which fills the network before any test vector goes out. Next comes a walking-one payload, laid out in five-flit slots. The stream closes with a tail. Only the slot group of the sending node carries ones. The slots of the other sources stay zero, so that across the whole mesh only one wire is high at a time.

The block sorts the outcome into three results:
- **Clean pass:** every flit arrived and matched.
- **Payload mismatch:** at least one flit differed. The index of the first bad flit is kept.
- **Timeout:** no header arrived inside a fixed window. This is how a header corrupted in flight, and therefore misrouted, is detected.

Top module: `flit_response_checker`

## Requirements
- R1: After reset, `pass_o`, `payload_error_o` and `timeout_o` are 0 and `first_bad_idx_o` is 0.
- R2: A `start_i` pulse clears all three flags, loads `src_i` and re-arms the checker, including in the middle of a packet. The flags read 0 on the cycle after the start.
- R3: The expected packet is 171 flits long, in this order:
  - the header, at index 0;
  - 9 zero flits, at indices 1 to 9;
  - 32 payload slots of 5 flits each, at indices 10 to 169;
  - the tail, at index 170, equal to `TAIL_FLIT` (default 8'h00).
  
  `pass_o` rises on the cycle after flit 170 is accepted, and only if no flit mismatched. It is never set earlier.
- R4: The expected header on arrival has bit 7 equal to `src_i[0]` and bit 4 equal to `src_i[1]`. All its other bits are 0, because every hop count has already been decremented to zero.
- R5: Payload slot s (0..31) starts with a vector flit and continues with 4 zero flits. The vector is `1 << (s % 8)` when `s / 8` equals the source index, and 0 otherwise.
- R6: Any accepted flit that differs from its expected value sets `payload_error_o` on the next cycle. `pass_o` then stays 0 for that packet.
- R7: `first_bad_idx_o` holds the index of the first mismatching flit, where the header is index 0. Later mismatches in the same packet leave it unchanged.
- R8: If no valid flit is accepted within `TIMEOUT_CYC` clock edges after the start edge, `timeout_o` is set on edge number `TIMEOUT_CYC`. A header accepted on that same edge wins, and no timeout is raised.
- R9: Cycles with `flit_valid_i` low do not advance the flit index.
- R10: Flits that arrive while the checker is idle, finished or timed out are ignored. All outputs hold until the next start.
- R11: A flit presented in the same cycle as `start_i` is ignored, and the next accepted flit is taken as the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm pulse for a new packet |
| src_i | input | 2 | Expected source node index, sampled with `start_i` |
| flit_valid_i | input | 1 | Received flit is valid this cycle |
| flit_i | input | 8 | Received flit |
| pass_o | output | 1 | Whole packet received with no mismatch |
| payload_error_o | output | 1 | At least one flit mismatched |
| timeout_o | output | 1 | No header arrived in the window |
| first_bad_idx_o | output | 8 | Index of the first mismatching flit |

## Verification
Every result is registered, so it is due one clock after the edge that accepts the deciding flit. The mismatch flag and first index follow the edge of the bad flit. `pass_o` follows the edge of flit 170. `timeout_o` follows edge `TIMEOUT_CYC` counted from the start edge. The bench drives its inputs on the falling edge, advances one rising edge per flit or idle cycle, and samples at the next falling edge. Each check therefore lands exactly one edge after its stimulus. The timeout boundary is checked on both sides: one edge early, where no flag may be set, and on the exact edge, with and without a header arriving there.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2,
    ST_DONE = 2'd3
  } frc_state_e;

  typedef enum logic [1:0] {
    SEG_HDR  = 2'd0,
    SEG_PAD  = 2'd1,
    SEG_PAY  = 2'd2,
    SEG_TAIL = 2'd3
  } frc_seg_e;

  function automatic int packet_len(input int pad, input int flit_w,
                                    input int n_src, input int gap);
    return 1 + pad + flit_w * n_src * (gap + 1) + 1;
  endfunction

endpackage

// File: rtl/frc_expect.sv
module frc_expect
  import frc_pkg::*;
#(
  parameter int FLIT_W  = 8,
  parameter int NUM_SRC = 4,
  parameter int PAD_HDR = 9,
  parameter int GAP     = 4,
  parameter logic [FLIT_W-1:0] TAIL_FLIT = '0,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int SLOTS  = FLIT_W * NUM_SRC,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PAD_W  = $clog2(PAD_HDR + 1),
  localparam int GAP_W  = $clog2(GAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [SRC_W-1:0]  src,
  output logic [FLIT_W-1:0] exp_flit
);

  frc_seg_e          seg_q;
  logic [PAD_W-1:0]  pad_q;
  logic [GAP_W-1:0]  off_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      seg_q  <= SEG_HDR;
      pad_q  <= '0;
      off_q  <= '0;
      slot_q <= '0;
    end else if (adv) begin
      unique case (seg_q)
        SEG_HDR: begin
          seg_q <= SEG_PAD;
          pad_q <= '0;
        end
        SEG_PAD: begin
          if (pad_q == PAD_W'(PAD_HDR - 1)) begin
            seg_q  <= SEG_PAY;
            off_q  <= '0;
            slot_q <= '0;
          end else begin
            pad_q <= pad_q + 1'b1;
          end
        end
        SEG_PAY: begin
          if (off_q == GAP_W'(GAP)) begin
            off_q <= '0;
            if (slot_q == SLOT_W'(SLOTS - 1)) seg_q <= SEG_TAIL;
            else slot_q <= slot_q + 1'b1;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        default: seg_q <= SEG_TAIL;
      endcase
    end
  end

  logic [FLIT_W-1:0] hdr_arrival;
  always_comb begin
    hdr_arrival = '0;
    hdr_arrival[FLIT_W-1] = src[0];
    hdr_arrival[FLIT_W/2] = src[1];
  end

  int grp;
  int bitpos;
  always_comb begin
    grp    = int'(slot_q) / FLIT_W;
    bitpos = int'(slot_q) % FLIT_W;
  end

  always_comb begin
    exp_flit = '0;
    unique case (seg_q)
      SEG_HDR:  exp_flit = hdr_arrival;
      SEG_PAD:  exp_flit = '0;
      SEG_PAY:  if (off_q == '0 && grp == int'(src))
                  exp_flit = {{(FLIT_W-1){1'b0}}, 1'b1} << bitpos;
      default:  exp_flit = TAIL_FLIT;
    endcase
  end

  AST_HDR_THEN_PAD: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_HDR && adv && !load) |=> (seg_q == SEG_PAD)); // R3

  AST_TAIL_STICKS: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_TAIL && !load) |=> (seg_q == SEG_TAIL)); // R3

endmodule

// File: rtl/frc_timer.sv
module frc_timer #(
  parameter int LIMIT = 1024,
  localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (expired && run && !clear) |=> expired); // R8

endmodule

// File: rtl/frc_mismatch.sv
module frc_mismatch #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  output logic             err_o,
  output logic [IDX_W-1:0] first_o
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_o   <= 1'b0;
      first_o <= '0;
    end else if (hit && !err_o) begin
      err_o   <= 1'b1;
      first_o <= hit_idx;
    end
  end

  AST_FIRST_KEEP: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clear) |=> (err_o && $stable(first_o))); // R7

  AST_HIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (hit && !clear) |=> err_o); // R6

endmodule

// File: rtl/flit_response_checker.sv
module flit_response_checker
  import frc_pkg::*;
#(
  parameter int FLIT_W      = 8,
  parameter int NUM_SRC     = 4,
  parameter int PAD_HDR     = 9,
  parameter int GAP         = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter logic [FLIT_W-1:0] TAIL_FLIT = '0,
  localparam int SRC_W = $clog2(NUM_SRC),
  localparam int TOTAL = packet_len(PAD_HDR, FLIT_W, NUM_SRC, GAP),
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              flit_valid_i,
  input  logic [FLIT_W-1:0] flit_i,
  output logic              pass_o,
  output logic              payload_error_o,
  output logic              timeout_o,
  output logic [IDX_W-1:0]  first_bad_idx_o
);

  frc_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SRC_W-1:0]  src_q;
  logic [FLIT_W-1:0] exp_flit;
  logic              expired;
  logic              accept;
  logic              mismatch;
  logic              last_flit;

  assign accept    = !start_i && flit_valid_i &&
                     (state_q == ST_WAIT || state_q == ST_RECV);
  assign mismatch  = accept && (flit_i != exp_flit);
  assign last_flit = (idx_q == IDX_W'(TOTAL - 1));

  frc_expect #(
    .FLIT_W   (FLIT_W),
    .NUM_SRC  (NUM_SRC),
    .PAD_HDR  (PAD_HDR),
    .GAP      (GAP),
    .TAIL_FLIT(TAIL_FLIT)
  ) u_expect (
    .clk     (clk),
    .rst     (rst),
    .load    (start_i),
    .adv     (accept),
    .src     (src_q),
    .exp_flit(exp_flit)
  );

  frc_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_i),
    .run    (state_q == ST_WAIT),
    .expired(expired)
  );

  frc_mismatch #(
    .IDX_W(IDX_W)
  ) u_mismatch (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_i),
    .hit    (mismatch),
    .hit_idx(idx_q),
    .err_o  (payload_error_o),
    .first_o(first_bad_idx_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      src_q     <= '0;
      pass_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_WAIT;
      idx_q     <= '0;
      src_q     <= src_i;
      pass_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (accept) begin
      if (last_flit) begin
        state_q <= ST_DONE;
        pass_o  <= !(payload_error_o || mismatch);
      end else begin
        state_q <= ST_RECV;
        idx_q   <= idx_q + 1'b1;
      end
    end else if (state_q == ST_WAIT && expired) begin
      state_q   <= ST_DONE;
      timeout_o <= 1'b1;
    end
  end

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> (!payload_error_o && !timeout_o)); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!pass_o && !timeout_o && !payload_error_o)); // R2

  AST_TIMEOUT_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> $past(state_q == ST_WAIT && !flit_valid_i)); // R8

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && !start_i) |=>
      ($stable(pass_o) && $stable(timeout_o) && $stable(first_bad_idx_o))); // R10

  AST_IDLE_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!flit_valid_i && !start_i) |=> $stable(idx_q)); // R9

endmodule

// File: tb/tb_flit_response_checker.sv
module tb_flit_response_checker;

  localparam int FW    = 8;
  localparam int TOTAL = 171;
  localparam int TMO   = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [1:0]    src_i;
  logic          flit_valid_i;
  logic [FW-1:0] flit_i;
  logic          pass_o, payload_error_o, timeout_o;
  logic [7:0]    first_bad_idx_o;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  flit_response_checker #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i),
    .flit_valid_i(flit_valid_i), .flit_i(flit_i), .pass_o(pass_o),
    .payload_error_o(payload_error_o), .timeout_o(timeout_o),
    .first_bad_idx_o(first_bad_idx_o)
  );

  // {gap, src, bad1, xor1, bad2, xor2}; bad index 255 = no fault
  localparam logic [47:0] VEC [7] = '{
    {8'd0, 8'd0, 8'd255, 8'h00, 8'd255, 8'h00},  // clean, R3 R5
    {8'd1, 8'd3, 8'd255, 8'h00, 8'd255, 8'h00},  // clean with gaps, R9
    {8'd0, 8'd1, 8'd0,   8'h80, 8'd255, 8'h00},  // header fault, R4
    {8'd0, 8'd2, 8'd95,  8'h02, 8'd255, 8'h00},  // dropped one, R5
    {8'd1, 8'd0, 8'd42,  8'h10, 8'd100, 8'h01},  // two faults, R7
    {8'd0, 8'd3, 8'd170, 8'h01, 8'd255, 8'h00},  // tail fault, R3
    {8'd0, 8'd1, 8'd5,   8'h40, 8'd255, 8'h00}   // padding fault, R6
  };

  function automatic logic [FW-1:0] model(int s, int i);
    int p, slot, off;
    logic [FW-1:0] f;
    f = '0;
    if (i == 0) begin
      f[7] = s[0];
      f[4] = s[1];
    end else if (i >= 10 && i < 170) begin
      p = i - 10; slot = p / 5; off = p % 5;
      if (off == 0 && slot / 8 == s) f = 8'(1 << (slot % 8));
    end
    return f;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(int s);
    start_i = 1'b1; src_i = 2'(s);
    tick();
    start_i = 1'b0;
  endtask

  task automatic stream(int s, int n, int b1, int x1, int b2, int x2, bit gap);
    for (int i = 0; i < n; i++) begin
      if (gap && (i % 7 == 3)) begin
        flit_valid_i = 1'b0; flit_i = 8'hA5;
        tick();
      end
      flit_valid_i = 1'b1;
      flit_i = model(s, i);
      if (i == b1) flit_i = flit_i ^ 8'(x1);
      if (i == b2) flit_i = flit_i ^ 8'(x2);
      tick();
      if (i == 169) chk("R3 no early pass", int'(pass_o), 0);
    end
    flit_valid_i = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; src_i = '0; flit_valid_i = 1'b0; flit_i = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 pass", int'(pass_o), 0);
    chk("R1 perr", int'(payload_error_o), 0);
    chk("R1 tmo", int'(timeout_o), 0);
    chk("R1 idx", int'(first_bad_idx_o), 0);

    foreach (VEC[k]) begin
      automatic int gp = int'(VEC[k][47:40]);
      automatic int s  = int'(VEC[k][39:32]);
      automatic int b1 = int'(VEC[k][31:24]);
      automatic int x1 = int'(VEC[k][23:16]);
      automatic int b2 = int'(VEC[k][15:8]);
      automatic int x2 = int'(VEC[k][7:0]);
      automatic bit bad = (b1 < TOTAL) || (b2 < TOTAL);
      automatic int fi  = (b1 < b2) ? b1 : b2;
      do_start(s);
      chk("R2 cleared after start", int'(pass_o | payload_error_o | timeout_o), 0);
      stream(s, TOTAL, b1, x1, b2, x2, gp[0]);
      chk("R3 R6 pass", int'(pass_o), bad ? 0 : 1);
      chk("R6 payload_error", int'(payload_error_o), bad ? 1 : 0);
      chk("R8 no timeout", int'(timeout_o), 0);
      if (bad) chk("R7 first index", int'(first_bad_idx_o), fi);
    end

    // R8 timeout window, one edge early then exact edge
    do_start(2);
    repeat (TMO - 1) tick();
    chk("R8 not yet", int'(timeout_o), 0);
    tick();
    chk("R8 timeout", int'(timeout_o), 1);
    // R10 late flits ignored after timeout
    stream(2, 5, 255, 0, 255, 0, 1'b0);
    chk("R10 tmo holds", int'(timeout_o), 1);
    chk("R10 no pass", int'(pass_o), 0);
    chk("R10 no perr", int'(payload_error_o), 0);

    // R8 header on the final window edge wins
    do_start(0);
    repeat (TMO - 1) tick();
    stream(0, TOTAL, 255, 0, 255, 0, 1'b0);
    chk("R8 boundary no timeout", int'(timeout_o), 0);
    chk("R8 boundary pass", int'(pass_o), 1);

    // R10 flits after done ignored
    flit_valid_i = 1'b1; flit_i = 8'hFF;
    repeat (3) tick();
    flit_valid_i = 1'b0;
    chk("R10 pass holds", int'(pass_o), 1);
    chk("R10 perr stays", int'(payload_error_o), 0);

    // R11 flit alongside start is ignored
    start_i = 1'b1; src_i = 2'd1; flit_valid_i = 1'b1; flit_i = model(1, 0);
    tick();
    start_i = 1'b0;
    stream(1, TOTAL, 255, 0, 255, 0, 1'b0);
    chk("R11 start flit ignored", int'(pass_o), 1);
    chk("R11 no error", int'(payload_error_o), 0);

    // R2 restart mid-packet
    do_start(3);
    stream(3, 50, 3, 8'h08, 255, 0, 1'b0);
    chk("R2 fault seen", int'(payload_error_o), 1);
    chk("R7 idx 3", int'(first_bad_idx_o), 3);
    do_start(3);
    chk("R2 restart clears", int'(payload_error_o), 0);
    stream(3, TOTAL, 255, 0, 255, 0, 1'b0);
    chk("R2 restart pass", int'(pass_o), 1);

    report();
    $finish;
  end

endmodule